// File: doc/BRIEF.md
# Queued Slot SPI Master

This block is a SPI master that works through a queue of up to sixteen transfer slots without help from a processor. Each slot has three entries: a transmit word, a receive word and a command byte. The command byte gives the slot its own chip-select pattern and word width, and says whether chip select stays asserted into the next slot. Software fills the slots through a byte-wide register port, writes the first and last slot numbers, and sets a run bit. The block then shifts the slots in order, captures the reply of each slot into that slot's receive entry, and raises a completion flag and an interrupt when the last slot is done.

Serial clock rate, clock polarity and phase, and the width used by wide slots all come from a shared control register and a divisor register. The run bit clears itself at the end of the queue. A read-only pointer register shows which slot is being shifted, or the last slot of a finished queue.

Top module: `qslot_spi_master`

## Requirements
- R1: After reset the control register reads 0xA3 (master enable, 8-bit field, polarity 1, phase 1), the divisor reads 8, status, run and current pointer read 0, `irq` is low, `cs_n` is all ones and `sck` idles high.
- R2: Register addresses are: divisor 0x00, control 0x01, start pointer 0x02, end pointer 0x03, run 0x04 (bit 6), status 0x05 (bit 0), current pointer 0x06. Slot s has its transmit upper byte at 0x20+2s, lower byte at 0x21+2s, receive upper at 0x40+2s, lower at 0x41+2s, and command at 0x60+s. Slots run in increasing order from the start pointer to the end pointer and wrap past slot 15 to slot 0. During a run the current pointer shows the active slot; afterwards it shows the end slot.
- R3: While a slot shifts, `cs_n` equals bits 3:0 of its command byte (low means selected).
- R4: Command bit 7 set keeps `cs_n` at the slot's pattern after the slot, also after the final slot of the queue. Bit 7 clear drives `cs_n` to all ones after the slot.
- R5: Command bit 6 clear makes an 8-bit slot. Bit 6 set makes the slot as wide as control bits 5:2, where 0 means 16 bits.
- R6: Data goes out and comes in most significant bit first. A wide slot uses the upper and lower bytes as one 16-bit word whose low bits are shifted. An 8-bit slot sends the lower transmit byte, writes only the lower receive byte and leaves the upper receive byte unchanged.
- R7: One `sck` period lasts twice the divisor in system clocks. Divisor values below 8 act as 8.
- R8: Control bit 1 sets the idle level of `sck`. With control bit 0 clear, data is sampled on the first edge of each bit and changed on the second. With bit 0 set, data is changed on the first edge and sampled on the second. All four modes move the same data.
- R9: When the last slot ends, status bit 0 and `irq` go high and the run bit returns to 0.
- R10: Writing 0 to status bit 0 clears it and `irq`. Writing 1 has no effect.
- R11: A run write only starts a queue when control bit 7 (master enable) is set. If it is clear, the run bit stays 0 and no slot is shifted.
- R12: A slot's receive entry is written at its final sampling edge, before `cs_n` changes for that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register and slot address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Queue-complete interrupt, follows status bit 0 |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Peripheral selects, active low |

## Verification
The assertions assume that software leaves the control, divisor, pointer and command registers alone while a queue runs, and that no command byte uses an all-ones select pattern right after a held select. The bench writes its configuration only while the block is idle, waits for the interrupt before it touches any register, and uses select patterns with at least one low bit. Its peripheral model follows the polarity and phase it was told and streams bits across slot boundaries. This lets the same model check single slots in all four modes as well as multi-slot queues.

// File: rtl/qslot_spi_master.sv
module qslot_spi_master #(
  parameter int         SLOTS    = 16,
  parameter int         CSW      = 4,
  parameter int         AW       = 7,
  parameter int         DW       = 8,
  parameter int         DIV_MIN  = 8,
  parameter logic [7:0] DIV_RST  = 8'd8,
  parameter logic [7:0] CTRL_RST = 8'hA3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  output logic           irq,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [CSW-1:0] cs_n
);

  localparam int PW     = $clog2(SLOTS);
  localparam int A_DIV  = 0;
  localparam int A_CTRL = 1;
  localparam int A_QS   = 2;
  localparam int A_QE   = 3;
  localparam int A_RUN  = 4;
  localparam int A_STAT = 5;
  localparam int A_QCUR = 6;
  localparam int A_TX   = 32;
  localparam int A_RX   = A_TX + 2 * SLOTS;
  localparam int A_CMD  = A_RX + 2 * SLOTS;
  localparam int A_END  = A_CMD + SLOTS;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SETUP, S_SHIFT, S_HOLD, S_GAP} st_t;

  logic [DW-1:0] div_r;
  logic [7:0]    ctrl_r;
  logic [PW-1:0] qs_r, qe_r, ptr_r;
  logic          run_r, done_r;

  logic [7:0] tx_hi [SLOTS];
  logic [7:0] tx_lo [SLOTS];
  logic [7:0] rx_hi [SLOTS];
  logic [7:0] rx_lo [SLOTS];
  logic [7:0] cmd_m [SLOTS];

  st_t            state;
  logic [DW-1:0]  hcnt;
  logic [5:0]     k;
  logic [4:0]     scnt, wid;
  logic [15:0]    sh_tx;
  logic [14:0]    sh_rx;
  logic           mosi_r, sck_r, cont_l, w16_l;
  logic [CSW-1:0] cs_n_r;

  wire cpol = ctrl_r[1];
  wire cpha = ctrl_r[0];

  wire in_tx  = (int'(reg_addr) >= A_TX)  && (int'(reg_addr) < A_RX);
  wire in_rx  = (int'(reg_addr) >= A_RX)  && (int'(reg_addr) < A_CMD);
  wire in_cmd = (int'(reg_addr) >= A_CMD) && (int'(reg_addr) < A_END);
  wire [PW-1:0] s_tx  = PW'((reg_addr - AW'(A_TX)) >> 1);
  wire [PW-1:0] s_rx  = PW'((reg_addr - AW'(A_RX)) >> 1);
  wire [PW-1:0] s_cmd = PW'(reg_addr - AW'(A_CMD));

  wire [DW-1:0] div_eff = (div_r < DW'(DIV_MIN)) ? DW'(DIV_MIN) : div_r;
  wire active = (state == S_SETUP) || (state == S_SHIFT) || (state == S_HOLD) || (state == S_GAP);
  wire tick   = active && (hcnt == div_eff - DW'(1));
  wire last   = (ptr_r == qe_r);

  wire        w16_p = cmd_m[ptr_r][6];
  wire [4:0]  wid_p = w16_p ? ((ctrl_r[5:2] == 4'd0) ? 5'd16 : {1'b0, ctrl_r[5:2]}) : 5'd8;
  wire [15:0] word_p = w16_p ? {tx_hi[ptr_r], tx_lo[ptr_r]} : {8'h00, tx_lo[ptr_r]};
  wire [15:0] aligned = word_p << (5'd16 - wid_p);

  wire        smp    = (~k[0]) ^ cpha;
  wire        k_last = (k == {wid, 1'b0} - 6'd1);
  wire        rx_we  = (state == S_SHIFT) && tick && smp && (scnt == wid - 5'd1);
  wire [15:0] rxw    = {sh_rx, miso};

  wire start  = reg_wr && (reg_addr == AW'(A_RUN)) && reg_wdata[6] && ctrl_r[7] && (state == S_IDLE);
  wire finish = tick && last && (((state == S_HOLD) && cont_l) || (state == S_GAP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_r  <= DIV_RST;
      ctrl_r <= CTRL_RST;
      qs_r   <= '0;
      qe_r   <= '0;
      run_r  <= 1'b0;
      done_r <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == AW'(A_DIV))  div_r  <= reg_wdata;
      if (reg_wr && reg_addr == AW'(A_CTRL)) ctrl_r <= reg_wdata;
      if (reg_wr && reg_addr == AW'(A_QS))   qs_r   <= reg_wdata[PW-1:0];
      if (reg_wr && reg_addr == AW'(A_QE))   qe_r   <= reg_wdata[PW-1:0];
      if (start)       run_r <= 1'b1;
      else if (finish) run_r <= 1'b0;
      if (finish) done_r <= 1'b1;
      else if (reg_wr && reg_addr == AW'(A_STAT) && !reg_wdata[0]) done_r <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (reg_wr && in_tx) begin
      if (reg_addr[0]) tx_lo[s_tx] <= reg_wdata;
      else             tx_hi[s_tx] <= reg_wdata;
    end
    if (reg_wr && in_cmd) cmd_m[s_cmd] <= reg_wdata;
    if (rx_we) begin
      rx_lo[ptr_r] <= rxw[7:0];
      if (w16_l) rx_hi[ptr_r] <= rxw[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hcnt <= '0;
    else if (!active || tick) hcnt <= '0;
    else             hcnt <= hcnt + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      k      <= '0;
      scnt   <= '0;
      wid    <= 5'd8;
      sh_tx  <= '0;
      sh_rx  <= '0;
      mosi_r <= 1'b0;
      sck_r  <= CTRL_RST[1];
      cs_n_r <= '1;
      cont_l <= 1'b0;
      w16_l  <= 1'b0;
      ptr_r  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          sck_r <= cpol;
          if (start) begin
            ptr_r <= qs_r;
            state <= S_LOAD;
          end
        end
        S_LOAD: begin
          cs_n_r <= cmd_m[ptr_r][CSW-1:0];
          cont_l <= cmd_m[ptr_r][7];
          w16_l  <= w16_p;
          wid    <= wid_p;
          k      <= '0;
          scnt   <= '0;
          sh_rx  <= '0;
          sck_r  <= cpol;
          if (cpha) sh_tx <= aligned;
          else begin
            mosi_r <= aligned[15];
            sh_tx  <= {aligned[14:0], 1'b0};
          end
          state <= S_SETUP;
        end
        S_SETUP: if (tick) state <= S_SHIFT;
        S_SHIFT: if (tick) begin
          sck_r <= ~sck_r;
          k     <= k + 6'd1;
          if (smp) begin
            sh_rx <= {sh_rx[13:0], miso};
            scnt  <= scnt + 5'd1;
          end else begin
            mosi_r <= sh_tx[15];
            sh_tx  <= {sh_tx[14:0], 1'b0};
          end
          if (k_last) state <= S_HOLD;
        end
        S_HOLD: if (tick) begin
          if (!cont_l) begin
            cs_n_r <= '1;
            state  <= S_GAP;
          end else if (last) state <= S_IDLE;
          else begin
            ptr_r <= ptr_r + 1'b1;
            state <= S_LOAD;
          end
        end
        S_GAP: if (tick) begin
          if (last) state <= S_IDLE;
          else begin
            ptr_r <= ptr_r + 1'b1;
            state <= S_LOAD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_tx)       reg_rdata = reg_addr[0] ? tx_lo[s_tx] : tx_hi[s_tx];
    else if (in_rx)  reg_rdata = reg_addr[0] ? rx_lo[s_rx] : rx_hi[s_rx];
    else if (in_cmd) reg_rdata = cmd_m[s_cmd];
    else begin
      case (reg_addr)
        AW'(A_DIV):  reg_rdata = 8'(div_r);
        AW'(A_CTRL): reg_rdata = ctrl_r;
        AW'(A_QS):   reg_rdata = 8'(qs_r);
        AW'(A_QE):   reg_rdata = 8'(qe_r);
        AW'(A_RUN):  reg_rdata = {1'b0, run_r, 6'b0};
        AW'(A_STAT): reg_rdata = {7'b0, done_r};
        AW'(A_QCUR): reg_rdata = 8'(ptr_r);
        default:     reg_rdata = '0;
      endcase
    end
  end

  assign irq  = done_r;
  assign sck  = sck_r;
  assign mosi = mosi_r;
  assign cs_n = cs_n_r;

  p_cs_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT) |=> $stable(cs_n_r))
    else $error("select changed while a slot shifted");

  p_release_after_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&cs_n_r) |-> $past(state == S_HOLD || state == S_LOAD))
    else $error("select released outside slot end");

  p_half_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT && !tick) |=> $stable(sck_r))
    else $error("sck moved inside a half period");

  p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && $past(state == S_IDLE) && $stable(ctrl_r)) |-> (sck_r == ctrl_r[1]))
    else $error("sck idle level differs from polarity");

  p_done_clears_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_r) |-> !run_r)
    else $error("run bit still set at completion");

  p_start_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_r) |-> $past(ctrl_r[7]))
    else $error("queue started with master enable clear");

endmodule

// File: tb/sim_qslot_spi_master.sv
module sim_qslot_spi_master;
  localparam int CLK_P = 10;
  localparam logic [6:0] A_DIV = 7'h00, A_CTRL = 7'h01, A_QS = 7'h02, A_QE = 7'h03,
                         A_RUN = 7'h04, A_STAT = 7'h05, A_QCUR = 7'h06,
                         A_TX = 7'h20, A_RX = 7'h40, A_CMD = 7'h60;

  // cpol, cpha, wide, width field, tx word, peripheral reply
  localparam logic [38:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 4'd8,  16'h00A5, 16'h3C00},
    {1'b0, 1'b1, 1'b0, 4'd8,  16'h00C3, 16'h9600},
    {1'b1, 1'b0, 1'b0, 4'd8,  16'h005A, 16'hE100},
    {1'b1, 1'b1, 1'b0, 4'd8,  16'h0081, 16'h7E00},
    {1'b0, 1'b0, 1'b1, 4'd0,  16'hBEEF, 16'h1234},
    {1'b1, 1'b1, 1'b1, 4'd0,  16'h1357, 16'hFACE},
    {1'b0, 1'b1, 1'b1, 4'd12, 16'h0ABC, 16'h5A50},
    {1'b1, 1'b0, 1'b1, 4'd9,  16'h0155, 16'h8000}
  };

  logic clk = 1'b0, rst_n;
  logic reg_wr;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic irq, sck, mosi, miso;
  logic [3:0] cs_n;

  int errors = 0, checks = 0, rel_cnt = 0;
  logic [63:0] s_out, s_in;
  logic m_cpol, m_cpha, miso_b;
  time t_prev, t_last;

  always #(CLK_P / 2) clk = ~clk;
  assign miso = miso_b;

  qslot_spi_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sck(sck),
    .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // peripheral model: streams bits across slots
  always @(sck) begin
    if (cs_n != 4'hF) begin
      if ((sck != m_cpol) ^ m_cpha) s_in = {s_in[62:0], mosi};
      else begin
        miso_b = s_out[63];
        s_out  = s_out << 1;
      end
    end
  end

  always @(posedge sck) if (cs_n != 4'hF) begin
    t_prev = t_last;
    t_last = $time;
  end

  always @(cs_n) if (cs_n == 4'hF) rel_cnt++;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic preload(input logic [63:0] st);
    s_out = st;
    s_in  = '0;
    if (!m_cpha) begin
      miso_b = s_out[63];
      s_out  = s_out << 1;
    end
  endtask

  task automatic wait_done(input string tag);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (irq) break;
    end
    chk({tag, " completion irq"}, irq, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, hi_before;
    logic [38:0] e;
    logic [15:0] tx, ms, txw, exp_rx, mask;
    logic [3:0] bpw;
    logic w16;
    int w;

    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    s_out = '0; s_in = '0; m_cpol = 1'b1; m_cpha = 1'b1; miso_b = 1'b0;
    t_prev = 0; t_last = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); chk("R1 control", v, 8'hA3);
    rd(A_DIV, v);  chk("R1 divisor", v, 8'd8);
    rd(A_STAT, v); chk("R1 status", v, 8'h00);
    rd(A_RUN, v);  chk("R1 run", v, 8'h00);
    rd(A_QCUR, v); chk("R1 pointer", v, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 cs_n", cs_n, 4'hF);
    chk("R1 sck idle", sck, 1'b1);

    // table of single-slot vectors: R5 R6 R8 R12
    for (int i = 0; i < 8; i++) begin
      e = VEC[i];
      m_cpol = e[38]; m_cpha = e[37]; w16 = e[36]; bpw = e[35:32];
      tx = e[31:16]; ms = e[15:0];
      w = w16 ? ((bpw == 4'd0) ? 16 : int'(bpw)) : 8;
      mask = 16'((32'd1 << w) - 1);
      wr(A_CTRL, {1'b1, 1'b0, bpw, m_cpol, m_cpha});
      wr(A_TX, tx[15:8]);
      wr(A_TX + 7'd1, tx[7:0]);
      wr(A_CMD, {1'b0, w16, 2'b00, 4'b1110});
      wr(A_QS, 8'd0);
      wr(A_QE, 8'd0);
      rd(A_RX, hi_before);
      preload({ms, 48'h0});
      wr(A_RUN, 8'h40);
      wait_done("R9");
      exp_rx = ms >> (16 - w);
      txw = w16 ? tx : {8'h00, tx[7:0]};
      chk($sformatf("R8 R5 vector %0d mosi bits", i), s_in[15:0], txw & mask);
      rd(A_RX + 7'd1, v);
      chk($sformatf("R12 R6 vector %0d rx lower", i), v, exp_rx[7:0]);
      rd(A_RX, v);
      chk($sformatf("R6 vector %0d rx upper", i), v, w16 ? exp_rx[15:8] : hi_before);
      chk($sformatf("R4 vector %0d released", i), cs_n, 4'hF);
      wr(A_STAT, 8'h00);
    end

    // mode 3 for the rest
    m_cpol = 1'b1; m_cpha = 1'b1;
    wr(A_CTRL, 8'hA3);

    // R9 R10 status behaviour
    wr(A_TX + 7'd1, 8'h3D);
    wr(A_CMD, 8'h0E);
    preload(64'h0);
    wr(A_RUN, 8'h40);
    wait_done("R9");
    rd(A_RUN, v);  chk("R9 run bit self-clears", v, 8'h00);
    wr(A_STAT, 8'h01);
    rd(A_STAT, v); chk("R10 write 1 keeps status", v, 8'h01);
    chk("R10 irq kept", irq, 1'b1);
    wr(A_STAT, 8'h00);
    rd(A_STAT, v); chk("R10 write 0 clears status", v, 8'h00);
    chk("R10 irq cleared", irq, 1'b0);

    // R7 clamp and period
    wr(A_DIV, 8'd3);
    preload(64'h0);
    wr(A_RUN, 8'h40);
    wait_done("R7");
    chk("R7 clamped period", 32'((t_last - t_prev) / CLK_P), 32'd16);
    wr(A_STAT, 8'h00);
    wr(A_DIV, 8'd10);
    preload(64'h0);
    wr(A_RUN, 8'h40);
    wait_done("R7");
    chk("R7 period divisor 10", 32'((t_last - t_prev) / CLK_P), 32'd20);
    wr(A_STAT, 8'h00);
    wr(A_DIV, 8'd8);

    // R11 master enable clear
    wr(A_CTRL, 8'h23);
    wr(A_RUN, 8'h40);
    rd(A_RUN, v);  chk("R11 run ignored", v, 8'h00);
    repeat (60) @(negedge clk);
    chk("R11 no completion", irq, 1'b0);
    chk("R11 no select", cs_n, 4'hF);
    wr(A_CTRL, 8'hA3);

    // R2 R3 R4 multi-slot queue 2..4
    wr(A_TX + 7'd5, 8'h11); wr(A_CMD + 7'd2, 8'h8E);
    wr(A_TX + 7'd7, 8'h22); wr(A_CMD + 7'd3, 8'h0E);
    wr(A_TX + 7'd9, 8'h33); wr(A_CMD + 7'd4, 8'h0D);
    wr(A_QS, 8'd2); wr(A_QE, 8'd4);
    preload({24'hA1B2C3, 40'h0});
    rel_cnt = 0;
    wr(A_RUN, 8'h40);
    repeat (5) @(negedge clk);
    chk("R3 select pattern slot 2", cs_n, 4'b1110);
    rd(A_RUN, v);  chk("R2 run bit while busy", v, 8'h40);
    rd(A_QCUR, v); chk("R2 pointer at start", v, 8'd2);
    wait_done("R2");
    chk("R2 stream order", s_in[23:0], 24'h112233);
    chk("R4 select releases", rel_cnt, 2);
    rd(A_RX + 7'd5, v); chk("R2 rx slot 2", v, 8'hA1);
    rd(A_RX + 7'd7, v); chk("R2 rx slot 3", v, 8'hB2);
    rd(A_RX + 7'd9, v); chk("R2 rx slot 4", v, 8'hC3);
    rd(A_QCUR, v); chk("R2 pointer at end", v, 8'd4);
    wr(A_STAT, 8'h00);

    // R2 wrap from slot 15 to slot 0
    wr(A_TX + 7'd31, 8'h5C); wr(A_CMD + 7'd15, 8'h0E);
    wr(A_TX + 7'd1, 8'hE7);  wr(A_CMD, 8'h0E);
    wr(A_QS, 8'd15); wr(A_QE, 8'd0);
    preload({16'h0FF0, 48'h0});
    wr(A_RUN, 8'h40);
    wait_done("R2");
    chk("R2 wrap stream", s_in[15:0], 16'h5CE7);
    rd(A_RX + 7'd31, v); chk("R2 wrap rx slot 15", v, 8'h0F);
    rd(A_RX + 7'd1, v);  chk("R2 wrap rx slot 0", v, 8'hF0);
    rd(A_QCUR, v); chk("R2 wrap pointer", v, 8'd0);
    wr(A_STAT, 8'h00);

    // R4 hold select after final slot
    wr(A_TX + 7'd3, 8'h77); wr(A_CMD + 7'd1, 8'h8B);
    wr(A_QS, 8'd1); wr(A_QE, 8'd1);
    preload(64'h0);
    wr(A_RUN, 8'h40);
    wait_done("R4");
    repeat (20) @(negedge clk);
    chk("R4 select held after queue", cs_n, 4'b1011);
    chk("R4 sent byte", s_in[7:0], 8'h77);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule